// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block brings one switchable power island up and down in hardware. It owns a single control word that holds the island's switch, isolation, memory-repair and inrush-limit settings. Software can read the word and can write it while no sequence is running. A power-up request closes the power switches at the lowest inrush limit and raises the limit one step at a time until the switch reports power-good. It then releases electrical isolation, runs a memory-repair handshake and finally releases functional isolation. A power-down request undoes the isolation steps in reverse order and opens the switches.

Every wait is bounded by a cycle count derived from the `CYC_PER_US` parameter. The power-good window is three microseconds per inrush step and the repair window is one microsecond. A timeout unwinds whatever the sequence has already applied, in stages, and reports an error. `busy` stays high while a sequence runs. The final cycle of a sequence raises either `donePulse` or `errPulse` for exactly one cycle. A request that arrives while the block is busy is dropped and sets a sticky flag.

Top module: `island_power_seq`

## Requirements
- R1: After reset, every output is low and `rdData` reads zero, apart from the live status bits 1 (`pwrGood`) and 4 (`repairDone`).
- R2: While the block is idle and no request is present, a write whose byte 31:24 equals 0x5A loads the control word: bit 0 switch enable, bit 2 electrical isolation release, bit 3 repair request, bit 5 functional isolation release, bit 12 island enable, bits 14:13 inrush code. A write with any other top byte changes nothing. Reads return these fields plus bit 1 power-good and bit 4 repair-done, with every other bit zero.
- R3: A power-up request that finds the switch enable already set changes no field. It raises `donePulse` one cycle after the request.
- R4: Power-up sets the switch enable together with an inrush code, starting at 0. It then waits up to 3*`CYC_PER_US` cycles for power-good. On each miss it raises the code by one, up to 3. When power-up and power-down requests arrive in the same cycle, power-up is taken.
- R5: After power-good the following steps occur on successive cycles: electrical isolation release is set, then the repair request is set, then the block waits up to `CYC_PER_US` cycles for repair-done. Once repair-done is seen, functional isolation release is set and `donePulse` follows.
- R6: If power-good has not appeared by the end of the window at code 3, the switch enable and the inrush code are cleared and `errPulse` is raised.
- R7: If repair-done times out, electrical isolation release is cleared first, then the switch enable and inrush code on the next cycle, and then `errPulse` is raised.
- R8: Power-down clears the functional isolation release, then the electrical isolation release, then the switch enable, one per cycle, followed by `donePulse`.
- R9: `busy` is high from the cycle after an accepted request through the cycle of its `donePulse` or `errPulse`. The two pulses are one cycle wide and never coincide.
- R10: A request seen while `busy` is high starts nothing. It sets `rejected`, which stays high until reset.
- R11: A register write seen while `busy` is high, or in the same cycle as a request, is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqOn | input | 1 | Power-up request, one cycle |
| reqOff | input | 1 | Power-down request, one cycle |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Write data, key byte in bits 31:24 |
| rdData | output | 32 | Control word readback with live status |
| pwrGood | input | 1 | Power-good from the island switch |
| repairDone | input | 1 | Completion from the memory-repair engine |
| switchEn | output | 1 | Closes the island power switches |
| inrushCode | output | 2 | Inrush current limit code |
| elecIsoRel | output | 1 | Electrical isolation released |
| repairReq | output | 1 | Memory repair request |
| funcIsoRel | output | 1 | Functional isolation released |
| islandEn | output | 1 | Island enable bit of the control word |
| busy | output | 1 | A sequence is running |
| donePulse | output | 1 | Sequence finished without error |
| errPulse | output | 1 | Sequence ended on a timeout |
| rejected | output | 1 | Sticky: a request arrived while busy |

## Verification
The hardest situation to reach from the ports is a repair-done timeout that follows a successful ramp. To get there, power-good must arrive while the repair engine stays silent. A close second is exhausting the ramp at the last inrush code. The bench models the switch as a power-good source with a programmable code threshold and delay, and models the repair engine with a programmable response delay. Setting the threshold above 3 drives the ramp through all four codes into the failure unwind. Setting a long repair delay after a low threshold produces the staged repair rollback. A mid-ramp request and a mid-ramp write exercise the rejection paths.

// File: rtl/island_pwr_pkg.sv
package island_pwr_pkg;

  localparam int INR_W       = 2;
  localparam int WORD_W      = 32;
  localparam logic [7:0] WR_KEY = 8'h5A;

  // bit positions decoded by software
  localparam int B_SW    = 0;
  localparam int B_PG    = 1;
  localparam int B_ELEC  = 2;
  localparam int B_REP   = 3;
  localparam int B_RDONE = 4;
  localparam int B_FUNC  = 5;
  localparam int B_EN    = 12;
  localparam int B_INR   = 13;

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_PGWAIT, S_ELEC, S_REPREQ, S_REPWAIT, S_FUNC,
    S_DNFUNC, S_DNELEC, S_DNSW, S_FAILISO, S_FAILSW, S_FINOK, S_FINERR
  } ctlState_t;

  typedef struct packed {
    logic             regWrite;
    logic             setRamp;
    logic [INR_W-1:0] rampCode;
    logic             setElec;
    logic             clrElec;
    logic             setRep;
    logic             setFunc;
    logic             clrFunc;
    logic             clrSw;
    logic             clrSwInr;
    logic             clrTimer;
  } dpStrobe_t;

endpackage

// File: rtl/island_pwr_dp.sv
module island_pwr_dp
  import island_pwr_pkg::*;
#(
  parameter int CYC_PER_US = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                pwrGood,
  input  logic                repairDone,
  output logic [WORD_W-1:0]   rdData,
  output logic                switchEn,
  output logic [INR_W-1:0]    inrushCode,
  output logic                elecIsoRel,
  output logic                repairReq,
  output logic                funcIsoRel,
  output logic                islandEn,
  output logic                pgExpired,
  output logic                rpExpired
);

  localparam int PG_CYC = 3 * CYC_PER_US;
  localparam int RP_CYC = CYC_PER_US;
  localparam int TW     = $clog2(PG_CYC + 1);
  localparam logic [TW-1:0] PG_LAST = TW'(PG_CYC - 1);
  localparam logic [TW-1:0] RP_LAST = TW'(RP_CYC - 1);

  logic          keyOk;
  logic [TW-1:0] waitCnt;

  assign keyOk = stb.regWrite && (wrData[WORD_W-1 -: 8] == WR_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switchEn   <= 1'b0;
      inrushCode <= '0;
      elecIsoRel <= 1'b0;
      repairReq  <= 1'b0;
      funcIsoRel <= 1'b0;
      islandEn   <= 1'b0;
    end else begin
      if (keyOk) begin
        switchEn   <= wrData[B_SW];
        elecIsoRel <= wrData[B_ELEC];
        repairReq  <= wrData[B_REP];
        funcIsoRel <= wrData[B_FUNC];
        islandEn   <= wrData[B_EN];
        inrushCode <= wrData[B_INR +: INR_W];
      end
      if (stb.setRamp) begin
        switchEn   <= 1'b1;
        inrushCode <= stb.rampCode;
      end
      if (stb.setElec) elecIsoRel <= 1'b1;
      if (stb.clrElec) elecIsoRel <= 1'b0;
      if (stb.setRep)  repairReq  <= 1'b1;
      if (stb.setFunc) funcIsoRel <= 1'b1;
      if (stb.clrFunc) funcIsoRel <= 1'b0;
      if (stb.clrSw)   switchEn   <= 1'b0;
      if (stb.clrSwInr) begin
        switchEn   <= 1'b0;
        inrushCode <= '0;
      end
    end
  end

  // one window timer shared by both waits, saturating at the longer limit
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrTimer) waitCnt <= '0;
    else if (waitCnt != PG_LAST) waitCnt <= waitCnt + 1'b1;
  end

  assign pgExpired = (waitCnt == PG_LAST);
  assign rpExpired = (waitCnt == RP_LAST);

  always_comb begin
    rdData               = '0;
    rdData[B_SW]         = switchEn;
    rdData[B_PG]         = pwrGood;
    rdData[B_ELEC]       = elecIsoRel;
    rdData[B_REP]        = repairReq;
    rdData[B_RDONE]      = repairDone;
    rdData[B_FUNC]       = funcIsoRel;
    rdData[B_EN]         = islandEn;
    rdData[B_INR +: INR_W] = inrushCode;
  end

endmodule

// File: rtl/island_pwr_ctl.sv
module island_pwr_ctl
  import island_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqOn,
  input  logic      reqOff,
  input  logic      wrEn,
  input  logic      swOn,
  input  logic      pwrGood,
  input  logic      repairDone,
  input  logic      pgExpired,
  input  logic      rpExpired,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      donePulse,
  output logic      errPulse,
  output logic      rejected
);

  localparam logic [INR_W-1:0] TOP_CODE = {INR_W{1'b1}};

  ctlState_t        state, stateNxt;
  logic [INR_W-1:0] step, stepNxt;
  logic             anyReq;

  assign anyReq = reqOn || reqOff;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    stepNxt  = step;
    unique case (state)
      S_IDLE: begin
        if (reqOn) begin
          stepNxt  = '0;
          stateNxt = swOn ? S_FINOK : S_RAMP;
        end else if (reqOff) begin
          stateNxt = S_DNFUNC;
        end else begin
          stb.regWrite = wrEn;
        end
      end
      S_RAMP: begin
        stb.setRamp  = 1'b1;
        stb.rampCode = step;
        stb.clrTimer = 1'b1;
        stateNxt     = S_PGWAIT;
      end
      S_PGWAIT: begin
        if (pwrGood) stateNxt = S_ELEC;
        else if (pgExpired) begin
          if (step == TOP_CODE) stateNxt = S_FAILSW;
          else begin
            stepNxt  = step + 1'b1;
            stateNxt = S_RAMP;
          end
        end
      end
      S_ELEC: begin
        stb.setElec = 1'b1;
        stateNxt    = S_REPREQ;
      end
      S_REPREQ: begin
        stb.setRep   = 1'b1;
        stb.clrTimer = 1'b1;
        stateNxt     = S_REPWAIT;
      end
      S_REPWAIT: begin
        if (repairDone) stateNxt = S_FUNC;
        else if (rpExpired) stateNxt = S_FAILISO;
      end
      S_FUNC: begin
        stb.setFunc = 1'b1;
        stateNxt    = S_FINOK;
      end
      S_DNFUNC: begin
        stb.clrFunc = 1'b1;
        stateNxt    = S_DNELEC;
      end
      S_DNELEC: begin
        stb.clrElec = 1'b1;
        stateNxt    = S_DNSW;
      end
      S_DNSW: begin
        stb.clrSw = 1'b1;
        stateNxt  = S_FINOK;
      end
      S_FAILISO: begin
        stb.clrElec = 1'b1;
        stateNxt    = S_FAILSW;
      end
      S_FAILSW: begin
        stb.clrSwInr = 1'b1;
        stateNxt     = S_FINERR;
      end
      S_FINOK:  stateNxt = S_IDLE;
      S_FINERR: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      step     <= '0;
      rejected <= 1'b0;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
      if (anyReq && state != S_IDLE) rejected <= 1'b1;
    end
  end

  assign busy      = (state != S_IDLE);
  assign donePulse = (state == S_FINOK);
  assign errPulse  = (state == S_FINERR);

endmodule

// File: rtl/island_power_seq.sv
module island_power_seq
  import island_pwr_pkg::*;
#(
  parameter int CYC_PER_US = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqOn,
  input  logic        reqOff,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        pwrGood,
  input  logic        repairDone,
  output logic        switchEn,
  output logic [1:0]  inrushCode,
  output logic        elecIsoRel,
  output logic        repairReq,
  output logic        funcIsoRel,
  output logic        islandEn,
  output logic        busy,
  output logic        donePulse,
  output logic        errPulse,
  output logic        rejected
);

  dpStrobe_t stb;
  logic      pgExpired;
  logic      rpExpired;

  island_pwr_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqOn      (reqOn),
    .reqOff     (reqOff),
    .wrEn       (wrEn),
    .swOn       (switchEn),
    .pwrGood    (pwrGood),
    .repairDone (repairDone),
    .pgExpired  (pgExpired),
    .rpExpired  (rpExpired),
    .stb        (stb),
    .busy       (busy),
    .donePulse  (donePulse),
    .errPulse   (errPulse),
    .rejected   (rejected)
  );

  island_pwr_dp #(.CYC_PER_US(CYC_PER_US)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .pwrGood    (pwrGood),
    .repairDone (repairDone),
    .rdData     (rdData),
    .switchEn   (switchEn),
    .inrushCode (inrushCode),
    .elecIsoRel (elecIsoRel),
    .repairReq  (repairReq),
    .funcIsoRel (funcIsoRel),
    .islandEn   (islandEn),
    .pgExpired  (pgExpired),
    .rpExpired  (rpExpired)
  );

endmodule

// File: rtl/island_power_seq_chk.sv
module island_power_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       donePulse,
  input logic       errPulse,
  input logic       rejected,
  input logic       switchEn,
  input logic [1:0] inrushCode,
  input logic       elecIsoRel,
  input logic       funcIsoRel
);

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R9

  AST_END_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || errPulse) |-> busy); // R9

  AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rejected |=> rejected); // R10

  AST_RAMP_UPWARD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && switchEn && $past(switchEn) && inrushCode != $past(inrushCode))
      |-> inrushCode == $past(inrushCode) + 2'd1); // R4

  AST_FUNC_AFTER_ELEC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(funcIsoRel)) |-> elecIsoRel); // R5

  AST_ELEC_AFTER_FUNC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $fell(elecIsoRel)) |-> !funcIsoRel); // R8

  AST_ERR_SWITCH_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!switchEn && inrushCode == 2'd0)); // R6

endmodule

bind island_power_seq island_power_seq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .donePulse  (donePulse),
  .errPulse   (errPulse),
  .rejected   (rejected),
  .switchEn   (switchEn),
  .inrushCode (inrushCode),
  .elecIsoRel (elecIsoRel),
  .funcIsoRel (funcIsoRel)
);

// File: tb/island_power_seq_tb_top.sv
`timescale 1ns/1ps
module island_power_seq_tb_top;

  localparam int CPU    = 4;
  localparam int PG_WIN = 3 * CPU;
  localparam int RP_WIN = CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqOn = 1'b0, reqOff = 1'b0, wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic pwrGood, repairDone;
  logic switchEn, elecIsoRel, repairReq, funcIsoRel, islandEn;
  logic [1:0] inrushCode;
  logic busy, donePulse, errPulse, rejected;

  always #4 clk = ~clk; // 125 MHz

  island_power_seq #(.CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .reqOff(reqOff), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .pwrGood(pwrGood), .repairDone(repairDone),
    .switchEn(switchEn), .inrushCode(inrushCode), .elecIsoRel(elecIsoRel),
    .repairReq(repairReq), .funcIsoRel(funcIsoRel), .islandEn(islandEn),
    .busy(busy), .donePulse(donePulse), .errPulse(errPulse), .rejected(rejected)
  );

  // ---- environment: island switch and repair engine ----
  int pgThr = 4, pgDelay = 0, rpDelay = 0;
  int pgCnt = 0, rpCnt = 0;
  logic pgCond;
  assign pgCond     = switchEn && (int'(inrushCode) >= pgThr);
  assign pwrGood    = pgCond && (pgCnt >= pgDelay);
  assign repairDone = repairReq && (rpCnt >= rpDelay);
  always @(posedge clk) begin
    pgCnt <= pgCond ? pgCnt + 1 : 0;
    rpCnt <= repairReq ? rpCnt + 1 : 0;
  end

  // ---- behavioural reference ----
  logic eSw, eElec, eRep, eFunc, eEn, eBusy, eDone, eErr, eRej;
  logic [1:0] eInr;
  int mPh, mStep, mCnt, nx;

  always @(posedge clk) begin
    if (!rstN) begin
      {eSw, eElec, eRep, eFunc, eEn, eBusy, eDone, eErr, eRej} = '0;
      eInr = 0; mPh = 0; mStep = 0; mCnt = 0;
    end else begin
      nx = mPh;
      if ((reqOn || reqOff) && mPh != 0) eRej = 1'b1;
      case (mPh)
        0: if (reqOn) begin
             mStep = 0;
             nx = eSw ? 50 : 10;
           end else if (reqOff) nx = 30;
           else if (wrEn && wrData[31:24] == 8'h5A) begin
             eSw = wrData[0]; eElec = wrData[2]; eRep = wrData[3];
             eFunc = wrData[5]; eEn = wrData[12]; eInr = wrData[14:13];
           end
        10: begin eSw = 1; eInr = 2'(mStep); mCnt = 0; nx = 11; end
        11: if (pwrGood) nx = 20;
            else if (mCnt == PG_WIN - 1) begin
              if (mStep == 3) nx = 41;
              else begin mStep = mStep + 1; nx = 10; end
            end else mCnt = mCnt + 1;
        20: begin eElec = 1; nx = 21; end
        21: begin eRep = 1; mCnt = 0; nx = 22; end
        22: if (repairDone) nx = 23;
            else if (mCnt == RP_WIN - 1) nx = 40;
            else mCnt = mCnt + 1;
        23: begin eFunc = 1; nx = 50; end
        30: begin eFunc = 0; nx = 31; end
        31: begin eElec = 0; nx = 32; end
        32: begin eSw = 0; nx = 50; end
        40: begin eElec = 0; nx = 41; end
        41: begin eSw = 0; eInr = 0; nx = 51; end
        default: nx = 0;
      endcase
      mPh   = nx;
      eBusy = (mPh != 0);
      eDone = (mPh == 50);
      eErr  = (mPh == 51);
    end
  end

  // ---- checking ----
  int checks = 0, errors = 0, doneSeen = 0, errSeen = 0, cycles = 0;
  string curReq = "R1";

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] eRd;
  always @(negedge clk) begin
    if (rstN) begin
      eRd = {17'b0, eInr, eEn, 6'b0, eFunc, repairDone, eRep, eElec, pwrGood, eSw};
      check(curReq, "per-cycle ports",
            {23'b0, rdData, switchEn, inrushCode, elecIsoRel, repairReq, funcIsoRel,
             islandEn, busy, donePulse, errPulse, rejected},
            {23'b0, eRd, eSw, eInr, eElec, eRep, eFunc, eEn, eBusy, eDone, eErr, eRej});
      if (donePulse) doneSeen++;
      if (errPulse) errSeen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic request(logic on, logic off);
    @(negedge clk); reqOn = on; reqOff = off;
    @(negedge clk); reqOn = 1'b0; reqOff = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  int d0, e0;

  initial begin
    tick(3);
    rstN = 1'b1;
    curReq = "R1";
    tick(2);
    check("R1", "reset readback", {32'b0, rdData}, 64'h0);
    check("R1", "reset busy/flags", {60'b0, busy, donePulse, errPulse, rejected}, 64'h0);

    curReq = "R2";
    wrReg(32'h11001021);                       // wrong key
    tick(1);
    check("R2", "bad key ignored", {32'b0, rdData}, 64'h0);
    wrReg(32'h5A005020);                       // en, inrush 2, func
    tick(1);
    check("R2", "keyed write", {32'b0, rdData}, 64'h0000_0000_0000_5020);
    wrReg(32'h5A000000);

    curReq = "R3/R9";
    wrReg(32'h5A000001);
    d0 = doneSeen;
    request(1, 0);
    check("R3", "done one cycle after request", {63'b0, donePulse}, 64'h1);
    waitIdle();
    check("R3", "done count", 64'(doneSeen - d0), 64'd1);
    check("R3", "fields untouched", {32'b0, rdData & 32'hFFFF_FFED}, 64'h1);
    wrReg(32'h5A000000);

    curReq = "R4/R5/R9/R10/R11";
    pgThr = 2; pgDelay = 1; rpDelay = 2;
    request(1, 0);
    tick(4);
    wrReg(32'h5A000000);                       // R11: dropped while busy
    request(0, 1);                             // R10: dropped while busy
    waitIdle();
    check("R10", "rejected sticky", {63'b0, rejected}, 64'h1);
    check("R4", "final inrush code", {62'b0, inrushCode}, 64'd2);
    check("R5", "isolation released", {62'b0, elecIsoRel, funcIsoRel}, 64'h3);
    check("R11", "switch still on", {63'b0, switchEn}, 64'h1);

    curReq = "R8/R9";
    request(0, 1);
    waitIdle();
    check("R8", "down state", {61'b0, switchEn, elecIsoRel, funcIsoRel}, 64'h0);
    wrReg(32'h5A000000);

    curReq = "R6/R9";
    pgThr = 4; e0 = errSeen;
    request(1, 0);
    waitIdle();
    check("R6", "err pulse", 64'(errSeen - e0), 64'd1);
    check("R6", "switch and code cleared", {32'b0, rdData}, 64'h0);

    curReq = "R7/R9";
    pgThr = 0; pgDelay = 0; rpDelay = 1000; e0 = errSeen;
    request(1, 0);
    waitIdle();
    check("R7", "err pulse", 64'(errSeen - e0), 64'd1);
    check("R7", "rolled back", {61'b0, switchEn, elecIsoRel, funcIsoRel}, 64'h0);
    wrReg(32'h5A000000);

    curReq = "R4";
    rpDelay = 0;
    request(1, 1);                             // both at once: power-up wins
    waitIdle();
    check("R4", "up taken over down", {62'b0, switchEn, funcIsoRel}, 64'h3);

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule